// File: doc/BRIEF.md
# Serial EEPROM Page Write Collector and Write-Cycle Timer

This block sits behind a two-wire serial protocol controller in a serial EEPROM model. It gathers the data bytes of one write transaction into an eight-byte page buffer. When the transaction ends, it copies the loaded bytes into the memory array through a synchronous write port. It then keeps a busy flag raised for a programmable write-cycle time. The controller uses that flag to refuse acknowledge-polling device words.

The controller pulses `addr_load` with the memory address received after the device word, and pulses `byte_vld` once for each data byte. It pulses `stop` when it sees a STOP condition. Only the three low address bits advance as bytes arrive, so a transaction longer than one page wraps inside the page and overwrites its earlier bytes. The write-protect level is taken at STOP. The controller reads `next_addr` to keep its current-address counter in step. Nothing reaches the array until STOP.

Top module: `eeprom_page_writer`

## Requirements
- R1: During reset and in the first cycle after it, `busy` is 0, `mem_we` is 0 and `next_addr` is 0.
- R2: When the block is not busy and `stop` is low, an `addr_load` pulse sets `next_addr` to `start_addr` and empties the page buffer. The next byte goes to that address.
- R3: Each accepted `byte_vld` stores the byte at offset `next_addr[2:0]` of the page. It then advances bits [2:0] of `next_addr` by one modulo 8 and leaves the upper bits unchanged.
- R4: When more than eight bytes arrive, the offset wraps to the first byte of the same page. A later byte replaces the earlier byte at the same offset, so each offset is written at most once per commit, with its last value.
- R5: On an accepted STOP with at least one loaded byte and `wp` low, one array write is issued per clock for each loaded offset, in ascending offset order, starting in the cycle after STOP. The write address is the upper bits of `next_addr` with the offset in bits [2:0].
- R6: On such a STOP, `busy` rises in the next cycle and stays high for max(`cycle_len`, number of loaded offsets) cycles. `busy` is never raised by anything else.
- R7: While `busy` is high, `byte_vld`, `addr_load` and `stop` have no effect. `next_addr` holds and no extra array write occurs.
- R8: If `wp` is high when STOP is accepted, no array write happens, `busy` stays low and the buffered bytes are discarded. A later STOP with no new bytes writes nothing.
- R9: A STOP with no bytes loaded since the last address load or STOP starts no write cycle and leaves `busy` low.
- R10: `wp` is sampled only at STOP. Raising it while `busy` is high does not suppress the remaining writes of that commit.
- R11: `stop` takes priority over `addr_load` and `byte_vld` in the same cycle, and those strobes are dropped. An `addr_load` before STOP discards the bytes collected under the previous address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| addr_load | input | 1 | Pulse: start a new transaction at `start_addr` |
| start_addr | input | ADDR_W | Memory address received from the bus |
| byte_vld | input | 1 | Pulse: one data byte received |
| byte_data | input | 8 | Data byte |
| stop | input | 1 | Pulse: STOP condition seen |
| wp | input | 1 | Write-protect level, 1 = protected |
| cycle_len | input | TMR_W | Write-cycle length in clock cycles |
| mem_we | output | 1 | Array write enable |
| mem_addr | output | ADDR_W | Array write address |
| mem_wdata | output | 8 | Array write data |
| busy | output | 1 | Write cycle in progress |
| next_addr | output | ADDR_W | Address the next byte or read would use |

## Verification
A wrong offset pointer or page base appears at `next_addr` one cycle after the byte that caused it. It appears again on `mem_addr` in the first commit cycle after STOP. A stale or corrupted valid mask shows up as a missing, extra or out-of-order write in the cycles right after STOP. A timer or drain fault makes `busy` fall on the wrong cycle. The reference model compares all of these every clock, so each fault is reported within one cycle of the point where it first reaches a port.

// File: rtl/eepw_pkg.sv
package eepw_pkg;

    localparam int unsigned DATA_W     = 8;
    localparam int unsigned PAGE_BYTES = 8;
    localparam int unsigned OFS_W      = $clog2(PAGE_BYTES);

    typedef logic [DATA_W-1:0]                   byte_t;
    typedef logic [PAGE_BYTES-1:0]               mask_t;
    typedef logic [OFS_W-1:0]                    ofs_t;
    typedef logic [PAGE_BYTES-1:0][DATA_W-1:0]   page_t;

    typedef struct packed {
        logic hit;
        ofs_t idx;
    } pick_t;

    // lowest set bit of a valid mask
    function automatic pick_t pick_lowest(mask_t m);
        pick_t r;
        r = '0;
        for (int i = PAGE_BYTES - 1; i >= 0; i--) begin
            if (m[i]) begin
                r.hit = 1'b1;
                r.idx = ofs_t'(i);
            end
        end
        return r;
    endfunction

    // in-page offset advance, wraps naturally at the page end
    function automatic ofs_t ofs_next(ofs_t o);
        return o + ofs_t'(1);
    endfunction

    // true when at most one bit of the mask is set
    function automatic logic at_most_one(mask_t m);
        return (m & (m - mask_t'(1))) == '0;
    endfunction

endpackage

// File: rtl/eepw_page_buf.sv
module eepw_page_buf
    import eepw_pkg::*;
#(
    parameter int unsigned ADDR_W = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hold,
    input  logic              clear,
    input  logic              addr_load,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              byte_vld,
    input  byte_t             byte_data,
    output page_t             page_q,
    output mask_t             mask_q,
    output logic [ADDR_W-1:0] cur_addr
);

    ofs_t ofs;
    assign ofs = cur_addr[OFS_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            page_q   <= '0;
            mask_q   <= '0;
            cur_addr <= '0;
        end else if (!hold) begin
            if (clear) begin
                mask_q <= '0;
            end else if (addr_load) begin
                cur_addr <= start_addr;
                mask_q   <= '0;
            end else if (byte_vld) begin
                page_q[ofs]           <= byte_data;
                mask_q[ofs]           <= 1'b1;
                cur_addr[OFS_W-1:0]   <= ofs_next(ofs);
            end
        end
    end

endmodule

// File: rtl/eepw_commit_seq.sv
module eepw_commit_seq
    import eepw_pkg::*;
#(
    parameter int unsigned ADDR_W = 9,
    localparam int unsigned UP_W  = ADDR_W - OFS_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              launch,
    input  mask_t             launch_mask,
    input  page_t             page_d,
    input  logic [UP_W-1:0]   page_base,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output byte_t             mem_wdata,
    output logic              drain_last
);

    mask_t pend_q;
    pick_t pk;

    assign pk         = pick_lowest(pend_q);
    assign mem_we     = pk.hit;
    assign mem_addr   = {page_base, pk.idx};
    assign mem_wdata  = page_d[pk.idx];
    assign drain_last = at_most_one(pend_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
        end else if (launch) begin
            pend_q <= launch_mask;
        end else if (pk.hit) begin
            pend_q[pk.idx] <= 1'b0;
        end
    end

endmodule

// File: rtl/eepw_cycle_timer.sv
module eepw_cycle_timer #(
    parameter int unsigned TMR_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             launch,
    input  logic [TMR_W-1:0] cycle_len,
    input  logic             drain_last,
    output logic             busy
);

    logic [TMR_W-1:0] tmr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            tmr_q <= '0;
            busy  <= 1'b0;
        end else if (launch) begin
            tmr_q <= cycle_len;
            busy  <= 1'b1;
        end else if (busy) begin
            if (tmr_q != '0) begin
                tmr_q <= tmr_q - TMR_W'(1);
            end
            if (tmr_q <= TMR_W'(1) && drain_last) begin
                busy <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/eeprom_page_writer.sv
module eeprom_page_writer
    import eepw_pkg::*;
#(
    parameter int unsigned ADDR_W = 9,
    parameter int unsigned TMR_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              addr_load,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              byte_vld,
    input  logic [7:0]        byte_data,
    input  logic              stop,
    input  logic              wp,
    input  logic [TMR_W-1:0]  cycle_len,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    output logic              busy,
    output logic [ADDR_W-1:0] next_addr
);

    page_t             page_q;
    mask_t             mask_q;
    logic [ADDR_W-1:0] cur_addr;
    logic              stop_ok;
    logic              launch;
    logic              drain_last;

    assign stop_ok   = stop && !busy;
    assign launch    = stop_ok && !wp && (mask_q != '0);
    assign next_addr = cur_addr;

    eepw_page_buf #(.ADDR_W(ADDR_W)) u_buf (
        .clk        (clk),
        .rst        (rst),
        .hold       (busy),
        .clear      (stop_ok),
        .addr_load  (addr_load),
        .start_addr (start_addr),
        .byte_vld   (byte_vld),
        .byte_data  (byte_data),
        .page_q     (page_q),
        .mask_q     (mask_q),
        .cur_addr   (cur_addr)
    );

    eepw_commit_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk         (clk),
        .rst         (rst),
        .launch      (launch),
        .launch_mask (mask_q),
        .page_d      (page_q),
        .page_base   (cur_addr[ADDR_W-1:OFS_W]),
        .mem_we      (mem_we),
        .mem_addr    (mem_addr),
        .mem_wdata   (mem_wdata),
        .drain_last  (drain_last)
    );

    eepw_cycle_timer #(.TMR_W(TMR_W)) u_tmr (
        .clk        (clk),
        .rst        (rst),
        .launch     (launch),
        .cycle_len  (cycle_len),
        .drain_last (drain_last),
        .busy       (busy)
    );

endmodule

// File: rtl/eepw_chk.sv
module eepw_chk
    import eepw_pkg::*;
#(
    parameter int unsigned ADDR_W = 9
) (
    input logic              clk,
    input logic              rst,
    input logic              addr_load,
    input logic [ADDR_W-1:0] start_addr,
    input logic              byte_vld,
    input logic              stop,
    input logic              wp,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              busy,
    input logic [ADDR_W-1:0] next_addr,
    input mask_t             mask_q
);

    assert_load_R2: assert property (@(posedge clk) disable iff (rst)
        (!busy && addr_load && !stop) |=> next_addr == $past(start_addr));

    assert_step_R3: assert property (@(posedge clk) disable iff (rst)
        (!busy && byte_vld && !addr_load && !stop) |=>
            (next_addr[OFS_W-1:0] == ofs_t'($past(next_addr[OFS_W-1:0]) + ofs_t'(1)))
            && (next_addr[ADDR_W-1:OFS_W] == $past(next_addr[ADDR_W-1:OFS_W])));

    assert_we_busy_R5: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> busy);

    assert_page_R5: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> mem_addr[ADDR_W-1:OFS_W] == next_addr[ADDR_W-1:OFS_W]);

    assert_launch_R6: assert property (@(posedge clk) disable iff (rst)
        (stop && !busy && !wp && mask_q != '0) |=> busy);

    assert_rise_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(stop));

    assert_frozen_R7: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(next_addr));

    assert_protect_R8: assert property (@(posedge clk) disable iff (rst)
        (stop && !busy && wp) |=> !busy);

    assert_empty_R9: assert property (@(posedge clk) disable iff (rst)
        (stop && !busy && mask_q == '0) |=> !busy);

endmodule

bind eeprom_page_writer eepw_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .addr_load  (addr_load),
    .start_addr (start_addr),
    .byte_vld   (byte_vld),
    .stop       (stop),
    .wp         (wp),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .busy       (busy),
    .next_addr  (next_addr),
    .mask_q     (mask_q)
);

// File: tb/tb_eeprom_page_writer.sv
`timescale 1ns/1ps
module tb_eeprom_page_writer;

    localparam int ADDR_W = 9;
    localparam int TMR_W  = 16;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              addr_load = 1'b0;
    logic [ADDR_W-1:0] start_addr = '0;
    logic              byte_vld = 1'b0;
    logic [7:0]        byte_data = '0;
    logic              stop = 1'b0;
    logic              wp = 1'b0;
    logic [TMR_W-1:0]  cycle_len = '0;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_addr;
    logic [7:0]        mem_wdata;
    logic              busy;
    logic [ADDR_W-1:0] next_addr;

    always #4 clk = ~clk;

    eeprom_page_writer #(.ADDR_W(ADDR_W), .TMR_W(TMR_W)) dut (
        .clk(clk), .rst(rst), .addr_load(addr_load), .start_addr(start_addr),
        .byte_vld(byte_vld), .byte_data(byte_data), .stop(stop), .wp(wp),
        .cycle_len(cycle_len), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .busy(busy), .next_addr(next_addr)
    );

    int checks = 0;
    int fails  = 0;
    int wr_count = 0;
    int busy_cycles = 0;
    bit done = 1'b0;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // behavioural reference model
    int  m_left = 0;
    int  m_addr = 0;
    bit  pv[8];
    int  pd[8];
    int  q_addr[$];
    int  q_dat[$];

    always begin
        @(posedge clk);
        #2;
        if (rst) begin
            m_left = 0; m_addr = 0;
            for (int i = 0; i < 8; i++) pv[i] = 1'b0;
            q_addr.delete(); q_dat.delete();
        end else if (m_left > 0) begin
            if (q_addr.size() > 0) begin
                void'(q_addr.pop_front());
                void'(q_dat.pop_front());
            end
            m_left--;
        end else if (stop) begin
            int n;
            n = 0;
            if (!wp) begin
                for (int i = 0; i < 8; i++) begin
                    if (pv[i]) begin
                        q_addr.push_back((m_addr & ~7) | i);
                        q_dat.push_back(pd[i]);
                        n++;
                    end
                end
                if (n > 0) m_left = (int'(cycle_len) > n) ? int'(cycle_len) : n;
            end
            for (int i = 0; i < 8; i++) pv[i] = 1'b0;
        end else if (addr_load) begin
            m_addr = int'(start_addr);
            for (int i = 0; i < 8; i++) pv[i] = 1'b0;
        end else if (byte_vld) begin
            pv[m_addr & 7] = 1'b1;
            pd[m_addr & 7] = int'(byte_data);
            m_addr = (m_addr & ~7) | ((m_addr + 1) & 7);
        end
        if (!rst) begin
            chk("R6 busy", int'(busy), int'(m_left > 0));
            chk("R5 mem_we", int'(mem_we), int'(q_addr.size() > 0));
            if (mem_we && q_addr.size() > 0) begin
                chk("R5 mem_addr", int'(mem_addr), q_addr[0]);
                chk("R4 mem_wdata", int'(mem_wdata), q_dat[0]);
            end
            chk("R3 next_addr", int'(next_addr), m_addr);
            if (mem_we) wr_count++;
            if (busy) busy_cycles++;
        end
    end

    task automatic do_load(input int a);
        @(negedge clk); addr_load = 1'b1; start_addr = ADDR_W'(a);
        @(negedge clk); addr_load = 1'b0;
    endtask

    task automatic do_put(input int d);
        @(negedge clk); byte_vld = 1'b1; byte_data = 8'(d);
        @(negedge clk); byte_vld = 1'b0;
    endtask

    task automatic do_stop();
        @(negedge clk); stop = 1'b1;
        @(negedge clk); stop = 1'b0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (busy) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #(8 * 100000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            finish_run();
        end
    end

    initial begin
        int w0, b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        chk("R1 busy", int'(busy), 0);
        chk("R1 mem_we", int'(mem_we), 0);
        chk("R1 next_addr", int'(next_addr), 0);

        // R2, R3, R5, R6: short write crossing the page end
        cycle_len = 16'd20;
        do_load(9'h035);
        chk("R2 next_addr", int'(next_addr), 'h035);
        do_put(8'h11); do_put(8'h22); do_put(8'h33);
        chk("R3 wrapped next_addr", int'(next_addr), 'h030);
        w0 = wr_count; b0 = busy_cycles;
        do_stop(); wait_idle();
        chk("R5 write count", wr_count - w0, 3);
        chk("R6 busy length", busy_cycles - b0, 20);

        // R4: eleven bytes into one page, timer shorter than drain
        cycle_len = 16'd3;
        do_load(9'h108);
        for (int i = 0; i < 11; i++) do_put(8'h40 + i);
        chk("R4 next_addr", int'(next_addr), 'h10B);
        w0 = wr_count; b0 = busy_cycles;
        do_stop(); wait_idle();
        chk("R4 write count", wr_count - w0, 8);
        chk("R6 busy drain length", busy_cycles - b0, 8);

        // R7: strobes during busy are ignored
        cycle_len = 16'd30;
        do_load(9'h040);
        do_put(8'h01); do_put(8'h02);
        w0 = wr_count;
        do_stop();
        do_put(8'hAA); do_load(9'h080); do_stop();
        wait_idle();
        chk("R7 next_addr", int'(next_addr), 'h042);
        chk("R7 write count", wr_count - w0, 2);

        // R8: protected STOP discards the buffer
        do_load(9'h010);
        do_put(8'h55); do_put(8'h66);
        wp = 1'b1;
        w0 = wr_count; b0 = busy_cycles;
        do_stop();
        repeat (3) @(negedge clk);
        wp = 1'b0;
        do_stop();
        repeat (3) @(negedge clk);
        chk("R8 write count", wr_count - w0, 0);
        chk("R8 busy cycles", busy_cycles - b0, 0);

        // R9: address-only transaction
        b0 = busy_cycles;
        do_load(9'h020); do_stop();
        repeat (3) @(negedge clk);
        chk("R9 busy cycles", busy_cycles - b0, 0);

        // R10: wp raised mid-cycle
        cycle_len = 16'd12;
        do_load(9'h150);
        for (int i = 0; i < 4; i++) do_put(8'h90 + i);
        w0 = wr_count;
        @(negedge clk); stop = 1'b1;
        @(negedge clk); stop = 1'b0; wp = 1'b1;
        wait_idle();
        wp = 1'b0;
        chk("R10 write count", wr_count - w0, 4);

        // R11: reload discards, STOP wins over a same-cycle byte
        cycle_len = 16'd0;
        do_load(9'h060); do_put(8'h07); do_put(8'h08);
        do_load(9'h070); do_put(8'h09);
        w0 = wr_count; b0 = busy_cycles;
        do_stop(); wait_idle();
        chk("R11 reload write count", wr_count - w0, 1);
        chk("R11 busy cycles", busy_cycles - b0, 1);
        do_load(9'h090); do_put(8'hC1);
        w0 = wr_count;
        @(negedge clk); stop = 1'b1; byte_vld = 1'b1; byte_data = 8'hC2;
        @(negedge clk); stop = 1'b0; byte_vld = 1'b0;
        wait_idle();
        chk("R11 same-cycle write count", wr_count - w0, 1);
        chk("R11 same-cycle next_addr", int'(next_addr), 'h091);

        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule